// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This controller moves ownership of a differential data lane from one end to the other while the lane runs in its low-power signalling mode. Two copies sit at the two ends of the same lane pair. The end that currently drives the lane starts a turnaround when `start` is pulsed. It plays out a fixed request pattern, holds the bridge level, and then lets go of the lane. The far end recognises the pattern, waits a programmable guard time, takes the lane by driving the bridge level itself, and then returns the lane to the stop level. Every interval is built from one programmable base count, `lpx_cycles`, given in clock cycles.

The lane is encoded as two bits. Bit 1 is the positive wire and bit 0 the negative wire. 2'b11 is stop, 2'b10 is the request level, 2'b00 is the bridge level and 2'b01 is never driven. The state machine has two groups of states. The transmitting states are STOP, LEAD, REQ10A, REQ00, REQ10B, GO, GET and EXIT10. The listening states are R_STOP, R_SAW10A, R_SAW00, R_SAW10B and SURE.

The named transitions are:
- STOP to LEAD on `start`.
- LEAD to REQ10A to REQ00 to REQ10B to GO, each after its interval.
- GO to R_STOP when the lane is released.
- R_STOP to R_SAW10A to R_SAW00 to R_SAW10B to SURE as the pattern is recognised, with a fall back to R_STOP on any unexpected level.
- SURE to GET after the guard time.
- GET to EXIT10 to STOP.

Top module: `lp_turnaround_ctrl`

## Requirements
- R1: After reset, an instance built with START_AS_TX=1 drives the lane (`tx_dir`=1) with stop 2'b11. An instance built with START_AS_TX=0 does not drive the lane (`tx_dir`=0). `ta_done` is 0 on both.
- R2: A `start` pulse sampled while driving stop begins the request. The lane shows 2'b11 for L more cycles, then 2'b10 for L, 2'b00 for L and 2'b10 for L. The bridge 2'b00 then follows for exactly 4·L cycles, after which `tx_dir` falls to 0. L is the effective base count.
- R3: `start` has no effect unless the instance is driving stop. This covers an instance that is listening and an instance that is already in the middle of a request.
- R4: A listening instance takes the lane only after it samples the contiguous levels 2'b10, 2'b00, 2'b10, 2'b00 on `lp_in`. Any other level in the middle of that pattern sends it back to waiting for the first 2'b10.
- R5: After sampling the final 2'b00 of the pattern, the listening instance waits S cycles and then raises `tx_dir` while driving 2'b00. Its rise therefore comes S+1 cycles after the lane first shows that 2'b00. S is `sure_cycles` clamped into the range L to 2·L.
- R6: The new owner drives 2'b00 for exactly 5·L cycles, then 2'b10 for L cycles, then stop 2'b11. `ta_done` pulses for one cycle in the first stop cycle.
- R7: An `lpx_cycles` value of 0 is treated as 1.
- R8: While `tx_dir` is 0 the drivers are released and `lp_out` reads 2'b11.
- R9: While driving, every level is held for at least L cycles before it changes.
- R10: The instance that released the lane becomes a listener, so a second turnaround returns ownership to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpx_cycles | input | CW | Base interval L in clock cycles (0 means 1) |
| sure_cycles | input | CW+1 | Guard wait before taking the lane, clamped to L..2·L |
| start | input | 1 | One-cycle request to hand the lane over |
| lp_in | input | 2 | Sampled lane levels {P, N} |
| lp_out | output | 2 | Driven lane levels {P, N} |
| tx_dir | output | 1 | 1: this end drives the lane; 0: drivers high-impedance |
| ta_done | output | 1 | One-cycle pulse when a taken lane reaches stop |

## Verification
The hardest situation to reach is a listener that sees part of the request pattern and then an unexpected level. In normal operation, two well-behaved ends never produce a broken pattern. The bench therefore ANDs a stimulus-driven level into the shared lane model, the way an open-drain wire behaves. While the owner idles at stop, it injects 2'b10, 2'b00, 2'b11, and then 2'b10, 2'b00, 2'b11 again. A listener that failed to fall back would take the lane after the second partial pattern, and the bench watches for that. Ownership is also passed back and forth under several base and guard settings, including guard values that must be clamped and a zero base count. This confirms that each end switches correctly between requester and listener.

// File: rtl/lp_ta_pkg.sv
package lp_ta_pkg;

    localparam logic [1:0] LN_STOP   = 2'b11;
    localparam logic [1:0] LN_REQ    = 2'b10;
    localparam logic [1:0] LN_BRIDGE = 2'b00;

    typedef enum logic [3:0] {
        S_STOP,
        S_LEAD,
        S_REQ10A,
        S_REQ00,
        S_REQ10B,
        S_GO,
        S_R_STOP,
        S_R_SAW10A,
        S_R_SAW00,
        S_R_SAW10B,
        S_SURE,
        S_GET,
        S_EXIT10
    } ta_state_e;

endpackage

// File: rtl/lp_ta_clamp.sv
module lp_ta_clamp #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] lpx_cycles,
    input  logic [CW:0]   sure_cycles,
    output logic [CW-1:0] lpx_eff,
    output logic [CW:0]   sure_eff
);
    logic [CW:0] lo_lim;
    logic [CW:0] hi_lim;

    always_comb begin
        lpx_eff = (lpx_cycles == '0) ? CW'(1) : lpx_cycles;
        lo_lim  = {1'b0, lpx_eff};
        hi_lim  = {lpx_eff, 1'b0};
        if (sure_cycles < lo_lim)
            sure_eff = lo_lim;
        else if (sure_cycles > hi_lim)
            sure_eff = hi_lim;
        else
            sure_eff = sure_cycles;
    end
endmodule

// File: rtl/lp_ta_timer.sv
module lp_ta_timer #(
    parameter int TW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + TW'(1);
    end

    assign expire = (cnt_q == (limit - TW'(1)));
endmodule

// File: rtl/lp_ta_fsm.sv
module lp_ta_fsm
    import lp_ta_pkg::*;
#(
    parameter int CW          = 8,
    parameter bit START_AS_TX = 1'b1,
    localparam int TW         = CW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    lp_in,
    input  logic [CW-1:0] lpx_eff,
    input  logic [CW:0]   sure_eff,
    input  logic          expire,
    output logic          clr,
    output logic [TW-1:0] limit,
    output logic [1:0]    lp_out,
    output logic          tx_dir,
    output logic          ta_done
);
    localparam ta_state_e RST_STATE = START_AS_TX ? S_STOP : S_R_STOP;

    ta_state_e state_q, state_d;
    logic      done_q;
    logic [TW-1:0] l1, l4, l5, ls;

    assign l1 = TW'(lpx_eff);
    assign l4 = TW'({lpx_eff, 2'b00});
    assign l5 = l4 + l1;
    assign ls = TW'(sure_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == S_EXIT10) && (state_d == S_STOP);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_STOP:     if (start)  state_d = S_LEAD;
            S_LEAD:     if (expire) state_d = S_REQ10A;
            S_REQ10A:   if (expire) state_d = S_REQ00;
            S_REQ00:    if (expire) state_d = S_REQ10B;
            S_REQ10B:   if (expire) state_d = S_GO;
            S_GO:       if (expire) state_d = S_R_STOP;
            S_R_STOP:   if (lp_in == LN_REQ) state_d = S_R_SAW10A;
            S_R_SAW10A: begin
                if (lp_in == LN_BRIDGE)   state_d = S_R_SAW00;
                else if (lp_in != LN_REQ) state_d = S_R_STOP;
            end
            S_R_SAW00: begin
                if (lp_in == LN_REQ)         state_d = S_R_SAW10B;
                else if (lp_in != LN_BRIDGE) state_d = S_R_STOP;
            end
            S_R_SAW10B: begin
                if (lp_in == LN_BRIDGE)   state_d = S_SURE;
                else if (lp_in != LN_REQ) state_d = S_R_STOP;
            end
            S_SURE:     if (expire) state_d = S_GET;
            S_GET:      if (expire) state_d = S_EXIT10;
            S_EXIT10:   if (expire) state_d = S_STOP;
            default:    state_d = RST_STATE;
        endcase
    end

    assign clr = (state_d != state_q);

    always_comb begin
        lp_out = LN_STOP;
        tx_dir = 1'b1;
        limit  = l1;
        unique case (state_q)
            S_STOP:     lp_out = LN_STOP;
            S_LEAD:     lp_out = LN_STOP;
            S_REQ10A:   lp_out = LN_REQ;
            S_REQ00:    lp_out = LN_BRIDGE;
            S_REQ10B:   lp_out = LN_REQ;
            S_GO: begin
                lp_out = LN_BRIDGE;
                limit  = l4;
            end
            S_R_STOP, S_R_SAW10A, S_R_SAW00, S_R_SAW10B: tx_dir = 1'b0;
            S_SURE: begin
                tx_dir = 1'b0;
                limit  = ls;
            end
            S_GET: begin
                lp_out = LN_BRIDGE;
                limit  = l5;
            end
            S_EXIT10:   lp_out = LN_REQ;
            default:    tx_dir = 1'b0;
        endcase
    end

    assign ta_done = done_q;
endmodule

// File: rtl/lp_turnaround_ctrl.sv
module lp_turnaround_ctrl #(
    parameter int CW          = 8,
    parameter bit START_AS_TX = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] lpx_cycles,
    input  logic [CW:0]   sure_cycles,
    input  logic          start,
    input  logic [1:0]    lp_in,
    output logic [1:0]    lp_out,
    output logic          tx_dir,
    output logic          ta_done
);
    localparam int TW = CW + 3;

    logic [CW-1:0] lpx_eff;
    logic [CW:0]   sure_eff;
    logic          clr;
    logic          expire;
    logic [TW-1:0] limit;

    lp_ta_clamp #(.CW(CW)) u_clamp (
        .lpx_cycles (lpx_cycles),
        .sure_cycles(sure_cycles),
        .lpx_eff    (lpx_eff),
        .sure_eff   (sure_eff)
    );

    lp_ta_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .limit (limit),
        .expire(expire)
    );

    lp_ta_fsm #(.CW(CW), .START_AS_TX(START_AS_TX)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .lp_in   (lp_in),
        .lpx_eff (lpx_eff),
        .sure_eff(sure_eff),
        .expire  (expire),
        .clr     (clr),
        .limit   (limit),
        .lp_out  (lp_out),
        .tx_dir  (tx_dir),
        .ta_done (ta_done)
    );
endmodule

// File: rtl/lp_ta_checker.sv
module lp_ta_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] lpx_cycles,
    input logic [1:0]    lp_out,
    input logic          tx_dir,
    input logic          ta_done
);
    localparam int RW = CW + 4;

    logic [CW-1:0] base_l;
    logic [1:0]    prev_q;
    logic          prev_tx_q;
    logic [RW-1:0] run_q;

    assign base_l = (lpx_cycles == '0) ? CW'(1) : lpx_cycles;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q    <= 2'b11;
            prev_tx_q <= 1'b0;
            run_q     <= '0;
        end else begin
            prev_q    <= lp_out;
            prev_tx_q <= tx_dir;
            if (lp_out != prev_q)
                run_q <= RW'(1);
            else if (run_q != '1)
                run_q <= run_q + RW'(1);
        end
    end

    a_r8_released_reads_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_dir |-> lp_out == 2'b11);

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ta_done |=> !ta_done);

    a_r6_done_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ta_done |-> (tx_dir && lp_out == 2'b11 && $past(lp_out) == 2'b10));

    a_r2_release_after_bridge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_dir) |-> $past(lp_out) == 2'b00);

    a_r5_take_with_bridge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_dir) |-> lp_out == 2'b00);

    a_r9_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dir && prev_tx_q && lp_out != prev_q) |-> run_q >= RW'(base_l));

    a_r2_never_01: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dir |-> lp_out != 2'b01);
endmodule

bind lp_turnaround_ctrl lp_ta_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lpx_cycles(lpx_cycles),
    .lp_out    (lp_out),
    .tx_dir    (tx_dir),
    .ta_done   (ta_done)
);

// File: tb/tb_lp_turnaround_ctrl.sv
module tb_lp_turnaround_ctrl;
    localparam int CW     = 8;
    localparam int CLK_PS = 10;

    typedef struct {
        logic [1:0] val;
        int         len;
        string      req;
    } seg_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] lpx_cycles = CW'(3);
    logic [CW:0]   sure_cycles = '0;
    logic          a_start = 1'b0, b_start = 1'b0;
    logic [1:0]    force_v = 2'b11;
    logic [1:0]    line;
    logic [1:0]    a_out, b_out;
    logic          a_dir, b_dir, a_done, b_done;

    int   n_checks = 0;
    int   n_errors = 0;
    seg_t exp_q[$];
    bit   mon_on = 1'b0;
    logic [1:0] seg_val = 2'b11;
    int   seg_len = 0;

    always #(CLK_PS/2) clk = ~clk;

    assign line = (a_dir ? a_out : 2'b11) & (b_dir ? b_out : 2'b11) & force_v;

    lp_turnaround_ctrl #(.CW(CW), .START_AS_TX(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .lpx_cycles(lpx_cycles), .sure_cycles(sure_cycles),
        .start(a_start), .lp_in(line), .lp_out(a_out), .tx_dir(a_dir), .ta_done(a_done)
    );

    lp_turnaround_ctrl #(.CW(CW), .START_AS_TX(1'b0)) peer (
        .clk(clk), .rst_n(rst_n), .lpx_cycles(lpx_cycles), .sure_cycles(sure_cycles),
        .start(b_start), .lp_in(line), .lp_out(b_out), .tx_dir(b_dir), .ta_done(b_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: compares each completed non-stop lane segment with the scoreboard
    always @(negedge clk) begin
        if (line != seg_val) begin
            if (mon_on && seg_val != 2'b11) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected segment", int'(seg_val), -1);
                end else begin
                    seg_t e;
                    e = exp_q.pop_front();
                    check(seg_val == e.val, {e.req, " level"}, int'(seg_val), int'(e.val));
                    check(seg_len == e.len, {e.req, " length"}, seg_len, e.len);
                end
            end
            seg_val = line;
            seg_len = 1;
        end else begin
            seg_len++;
        end
    end

    // driver: one full handover, owner is dut when from_dut is set
    task automatic run_ta(input bit from_dut, input int lv, input int sv, input bit poke);
        int le, se, tend;
        le = (lv == 0) ? 1 : lv;              // R7
        se = (sv < le) ? le : ((sv > 2*le) ? 2*le : sv);
        tend = 10*le + se + 3;
        lpx_cycles  = CW'(lv);
        sure_cycles = (CW+1)'(sv);
        exp_q.push_back('{2'b10, le, "R2"});
        exp_q.push_back('{2'b00, le, "R2"});
        exp_q.push_back('{2'b10, le, "R2"});
        exp_q.push_back('{2'b00, 5*le + se + 1, "R5"});
        exp_q.push_back('{2'b10, le, "R6"});
        @(negedge clk);
        if (from_dut) a_start = 1'b1; else b_start = 1'b1;
        @(negedge clk);
        a_start = 1'b0;
        b_start = 1'b0;
        for (int t = 0; t <= tend; t++) begin
            logic od, nd, ndone;
            od    = from_dut ? a_dir : b_dir;
            nd    = from_dut ? b_dir : a_dir;
            ndone = from_dut ? b_done : a_done;
            if (t == 0) check(od && line == 2'b11, "R2 lead stop", int'(line), 3);
            if (t == le - 1) check(line == 2'b11, "R2 lead length", int'(line), 3);
            if (t == 8*le - 1) check(od == 1'b1, "R2 hold before release", int'(od), 1);
            if (t == 8*le) check(od == 1'b0, "R2 release after 4L", int'(od), 0);
            if (t == 4*le + se) check(nd == 1'b0, "R5 wait not short", int'(nd), 0);
            if (t == 4*le + se + 1) check(nd == 1'b1, "R5 take after S+1", int'(nd), 1);
            if (t == 10*le + se) check(ndone == 1'b0, "R6 done early", int'(ndone), 0);
            if (t == 10*le + se + 1) check(ndone == 1'b1 && line == 2'b11, "R6 done pulse", int'(ndone), 1);
            if (t == 10*le + se + 2) check(ndone == 1'b0, "R6 done width", int'(ndone), 0);
            if (poke && t == le) begin
                // R3: start mid-request and on the listener
                a_start = 1'b1;
                b_start = 1'b1;
            end
            if (poke && t == le + 1) begin
                a_start = 1'b0;
                b_start = 1'b0;
            end
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R2 all segments seen", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic force_level(input logic [1:0] v, input int n);
        force_v = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(a_dir == 1'b1 && a_out == 2'b11, "R1 owner after reset", int'(a_dir), 1);
        check(b_dir == 1'b0, "R1 listener after reset", int'(b_dir), 0);
        check(a_done == 1'b0 && b_done == 1'b0, "R1 done low", int'(a_done | b_done), 0);
        check(b_out == 2'b11, "R8 released lane reads stop", int'(b_out), 3);
        mon_on = 1'b1;

        run_ta(1'b1, 3, 3, 1'b0);
        run_ta(1'b0, 3, 3, 1'b1);   // R10 ownership returns
        run_ta(1'b1, 4, 9, 1'b0);   // R5 clamp high
        run_ta(1'b0, 2, 0, 1'b1);   // R5 clamp low, R3
        run_ta(1'b1, 0, 0, 1'b0);   // R7 zero base
        run_ta(1'b0, 5, 7, 1'b0);

        // R3: start on the listener while the owner idles
        @(negedge clk);
        b_start = 1'b1;
        @(negedge clk);
        b_start = 1'b0;
        repeat (30) @(negedge clk);
        check(b_dir == 1'b0 && a_dir == 1'b1, "R3 listener start ignored", int'(b_dir), 0);
        check(line == 2'b11, "R3 lane stays stop", int'(line), 3);

        // R4: broken request patterns must not hand over the lane
        mon_on = 1'b0;
        lpx_cycles = CW'(2);
        force_level(2'b10, 3);
        force_level(2'b00, 3);
        force_level(2'b11, 3);
        force_level(2'b10, 3);
        force_level(2'b00, 3);
        force_level(2'b11, 3);
        repeat (40) @(negedge clk);
        check(b_dir == 1'b0, "R4 no takeover after broken pattern", int'(b_dir), 0);
        check(a_dir == 1'b1 && line == 2'b11, "R4 owner undisturbed", int'(line), 3);
        seg_val = line;
        seg_len = 1;
        mon_on = 1'b1;
        run_ta(1'b1, 2, 3, 1'b0);   // R4 recovery after abort

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule